// File: doc/BRIEF.md
# Byte-Wide NVM Program and Read Controller

This block sits between a processor's register bus and a byte-addressed non-volatile data array. Software sees three registers: an address register, a data register and a control register. It uses them to read one byte, or to run a self-timed program operation on one byte. A program operation erases and writes the byte, only erases it, or only writes it, chosen by a two-bit mode field.

A program operation is guarded. Software first writes the arm bit, and the program bit is accepted only during the short window in which the arm bit is still set. While an operation runs, the address, the mode and the read path are locked, and the processor is told to stall for a few cycles on each read and on each start. A level-type ready interrupt is raised whenever it is enabled and the block is idle.

There are two resets. `por_n` clears everything. `rst_n` is a system reset, and an operation already in flight survives it. The array lives outside the block. The block drives the array address and a one-cycle write strobe, and it takes combinational read data back. Operation lengths are parameters in clock cycles.

Top module: `nvm_ctrl`

## Requirements
- R1: Writing the control register with the arm bit (bit 2) set makes the arm bit read back as 1 for exactly 4 cycles after that write, and then it clears by itself. Writing the arm bit as 0 does nothing.
- R2: A control write with the program bit (bit 1) set starts an operation only if the block is armed at that clock edge and idle. Otherwise the busy state and the array stay unchanged. Writing arm and program together in one write does not start an operation.
- R3: The mode field is control bits 5:4. Mode 00 stores the data byte and lasts `EW_CYC` cycles. Mode 01 stores 0xFF and lasts `ER_CYC` cycles. Mode 10 stores the old byte ANDed with the data byte and lasts `WR_CYC` cycles. The array is written in the last cycle of the operation.
- R4: Mode 11 keeps the block busy for exactly one cycle and never writes the array.
- R5: While an operation runs, the program bit reads back as 1. It reads back as 0 from the cycle after the operation completes.
- R6: While busy, writes to the address register and to the mode field are ignored, and a read request (control bit 0) neither changes the data register nor raises a stall.
- R7: `cpu_stall_o` is high for 2 cycles after an accepted start and for 4 cycles after an accepted read. An accepted read loads the addressed byte into the data register in the same cycle.
- R8: `nvm_irq_o` is high exactly when the interrupt enable bit (control bit 3) is set and no operation is busy.
- R9: With `rst_n` low, the mode field and the address return to 0 only if the block is idle. The interrupt enable, the data register, the arm window and the stall are always cleared. An operation in flight runs to completion and writes the array.
- R10: After `por_n`, all registers read 0, the block is idle, and the stall and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| rst_n | input | 1 | Synchronous system reset, active low; spares a running operation |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Read data of the selected register |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_rdata_i | input | DATA_W | Array byte at `arr_addr_o` (combinational) |
| arr_we_o | output | 1 | Array write strobe, one cycle |
| arr_wdata_o | output | DATA_W | Byte written to the array |
| cpu_stall_o | output | 1 | Processor stall request |
| nvm_irq_o | output | 1 | Ready interrupt, level |

## Verification
The assertions take it for granted that software does not write the arm bit again while the block is already armed. A second arm write restarts the window, so the arm bit could legally stay high for more than 4 cycles, which the window check would reject. The assertions also assume that the array returns the addressed byte without delay. The bench writes the arm bit only once per start, and when it probes a late start it lets the window run out without re-arming. Its behavioural array is combinational on read.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_ERASE_WRITE = 2'b00,
    MODE_ERASE_ONLY  = 2'b01,
    MODE_WRITE_ONLY  = 2'b10,
    MODE_NONE        = 2'b11
  } nvm_mode_e;

  // register selects
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // control register bit positions
  localparam int CB_RD   = 0;
  localparam int CB_PROG = 1;
  localparam int CB_ARM  = 2;
  localparam int CB_IE   = 3;
  localparam int CB_MODE = 4;

  localparam int ARM_WIN     = 4;
  localparam int START_STALL = 2;
  localparam int READ_STALL  = 4;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WIN = 4,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic load,
  output logic armed
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (!rst_n)     cnt <= '0;
    else if (load)       cnt <= CW'(WIN);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign armed = (cnt != '0);
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dur,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  // Only power-on reset: a running operation survives the system reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             remain <= '0;
    else if (start)         remain <= dur;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
  assign last = (remain == CNT_W'(1));
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int START_LEN = 2,
  parameter int READ_LEN  = 4,
  localparam int MAXL = (START_LEN > READ_LEN) ? START_LEN : READ_LEN,
  localparam int CW   = $clog2(MAXL + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic on_start,
  input  logic on_read,
  output logic stall
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (!rst_n)     cnt <= '0;
    else if (on_read)    cnt <= CW'(READ_LEN);
    else if (on_start)   cnt <= CW'(START_LEN);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign stall = (cnt != '0);
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int EW_CYC = 68,
  parameter int ER_CYC = 36,
  parameter int WR_CYC = 36,
  localparam int BUS_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              arr_we_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic              cpu_stall_o,
  output logic              nvm_irq_o
);
  localparam int MAX_A = (EW_CYC > ER_CYC) ? EW_CYC : ER_CYC;
  localparam int MAX_D = (MAX_A > WR_CYC) ? MAX_A : WR_CYC;
  localparam int CNT_W = $clog2(MAX_D + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, op_data_q;
  nvm_mode_e         mode_q, op_mode_q, wmode;
  logic              ie_q;
  logic              busy_w, last_w, arm_w;
  logic              ctrl_wr, start, rd_go, arm_load;
  logic [CNT_W-1:0]  dur;

  assign ctrl_wr  = rst_n && bus_we && (bus_sel == SEL_CTRL);
  assign wmode    = nvm_mode_e'(bus_wdata[CB_MODE +: 2]);
  assign arm_load = ctrl_wr && bus_wdata[CB_ARM];
  assign start    = ctrl_wr && bus_wdata[CB_PROG] && arm_w && !busy_w;
  assign rd_go    = ctrl_wr && bus_wdata[CB_RD] && !busy_w && !start;

  always_comb begin
    unique case (wmode)
      MODE_ERASE_WRITE: dur = CNT_W'(EW_CYC);
      MODE_ERASE_ONLY:  dur = CNT_W'(ER_CYC);
      MODE_WRITE_ONLY:  dur = CNT_W'(WR_CYC);
      default:          dur = CNT_W'(1);
    endcase
  end

  nvm_arm_window #(.WIN(ARM_WIN)) u_arm (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .load(arm_load), .armed(arm_w)
  );

  nvm_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .por_n(por_n), .start(start), .dur(dur),
    .busy(busy_w), .last(last_w)
  );

  nvm_stall_gen #(.START_LEN(START_STALL), .READ_LEN(READ_STALL)) u_stall (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .on_start(start), .on_read(rd_go), .stall(cpu_stall_o)
  );

  // Software-visible registers.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q <= '0;
      data_q <= '0;
      mode_q <= MODE_ERASE_WRITE;
      ie_q   <= 1'b0;
    end else if (!rst_n) begin
      if (!busy_w) begin
        addr_q <= '0;
        mode_q <= MODE_ERASE_WRITE;
      end
      data_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (bus_we && bus_sel == SEL_ADDR && !busy_w)
        addr_q <= bus_wdata[ADDR_W-1:0];
      if (bus_we && bus_sel == SEL_DATA)
        data_q <= bus_wdata[DATA_W-1:0];
      else if (rd_go)
        data_q <= arr_rdata_i;
      if (ctrl_wr) begin
        ie_q <= bus_wdata[CB_IE];
        if (!busy_w) mode_q <= wmode;
      end
    end
  end

  // Operation snapshot, kept across the system reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      op_mode_q <= MODE_ERASE_WRITE;
      op_data_q <= '0;
    end else if (start) begin
      op_mode_q <= wmode;
      op_data_q <= data_q;
    end
  end

  assign arr_addr_o = addr_q;
  assign arr_we_o   = last_w && (op_mode_q != MODE_NONE);

  always_comb begin
    unique case (op_mode_q)
      MODE_ERASE_ONLY: arr_wdata_o = '1;
      MODE_WRITE_ONLY: arr_wdata_o = arr_rdata_i & op_data_q;
      default:         arr_wdata_o = op_data_q;
    endcase
  end

  assign nvm_irq_o = ie_q & ~busy_w;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_sel)
      SEL_ADDR: bus_rdata[ADDR_W-1:0] = addr_q;
      SEL_DATA: bus_rdata[DATA_W-1:0] = data_q;
      SEL_CTRL: begin
        bus_rdata[CB_PROG]      = busy_w;
        bus_rdata[CB_ARM]       = arm_w;
        bus_rdata[CB_IE]        = ie_q;
        bus_rdata[CB_MODE +: 2] = mode_q;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int AW  = 8,
  parameter int WIN = 4
) (
  input logic          clk,
  input logic          por_n,
  input logic          busy,
  input logic          arm,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr,
  input logic          irq,
  input logic          stall
);
  logic [3:0] arm_run, stall_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      arm_run   <= '0;
      stall_run <= '0;
    end else begin
      arm_run   <= arm ? ((arm_run == 4'hF) ? arm_run : arm_run + 1'b1) : '0;
      stall_run <= stall ? ((stall_run == 4'hF) ? stall_run : stall_run + 1'b1) : '0;
    end
  end

  p_arm_limit_r1: assert property (@(posedge clk) disable iff (!por_n)
    arm_run <= 4'(WIN));
  p_arm_full_r1: assert property (@(posedge clk) disable iff (!por_n)
    $fell(arm) |-> arm_run == 4'(WIN));
  p_start_armed_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(arm));
  p_write_ends_r3: assert property (@(posedge clk) disable iff (!por_n)
    arr_we |=> !busy);
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    (busy && $past(busy)) |-> $stable(arr_addr));
  p_start_stall_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> stall);
  p_stall_len_r7: assert property (@(posedge clk) disable iff (!por_n)
    stall_run <= 4'd4);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !irq);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.AW(ADDR_W), .WIN(nvm_ctrl_pkg::ARM_WIN)) u_chk (
  .clk(clk), .por_n(por_n), .busy(busy_w), .arm(arm_w), .arr_we(arr_we_o),
  .arr_addr(arr_addr_o), .irq(nvm_irq_o), .stall(cpu_stall_o)
);

// File: tb/sim_nvm_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_ctrl;
  localparam int AW = 8, DW = 8, BW = 8;
  localparam int EW = 20, ER = 10, WR = 12;

  logic clk = 0, por_n = 0, rst_n = 0, bus_we = 0;
  logic [1:0] bus_sel = 0;
  logic [BW-1:0] bus_wdata = 0, bus_rdata;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_rdata, arr_wdata;
  logic arr_we, stall, irq;
  logic [DW-1:0] mem [2**AW];
  int checks = 0, errors = 0;
  bit done = 0;
  bit cur_ie = 0;

  always #10 clk = ~clk;

  nvm_ctrl #(.ADDR_W(AW), .DATA_W(DW), .EW_CYC(EW), .ER_CYC(ER), .WR_CYC(WR)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_addr_o(arr_addr),
    .arr_rdata_i(arr_rdata), .arr_we_o(arr_we), .arr_wdata_o(arr_wdata),
    .cpu_stall_o(stall), .nvm_irq_o(irq));

  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

  function automatic logic [7:0] cw(bit rd, bit prog, bit arm, bit ie, logic [1:0] md);
    return {2'b00, md, ie, arm, prog, rd};
  endfunction

  function automatic logic [7:0] exp_byte(logic [1:0] md, logic [7:0] old, logic [7:0] d);
    case (md)
      2'b00: return d;
      2'b01: return 8'hFF;
      2'b10: return old & d;
      default: return old;
    endcase
  endfunction

  function automatic int exp_dur(logic [1:0] md);
    case (md) 2'b00: return EW; 2'b01: return ER; 2'b10: return WR; default: return 1; endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    bus_we = 1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_reg(logic [1:0] sel, output logic [7:0] v);
    bus_sel = sel; #1; v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] c;
    n = 0;
    rd_reg(2, c);
    while (c[1]) begin @(negedge clk); n++; rd_reg(2, c); end
  endtask

  task automatic nvm_read(logic [7:0] a, output logic [7:0] v);
    wr(0, a);
    wr(2, cw(1, 0, 0, cur_ie, 2'b00));
    rd_reg(1, v);
  endtask

  task automatic prog_op(logic [1:0] md, logic [7:0] a, logic [7:0] d, string tag);
    logic [7:0] old, got;
    int n;
    old = mem[a];
    wr(0, a); wr(1, d);
    wr(2, cw(0, 0, 1, cur_ie, md));
    wr(2, cw(0, 1, 0, cur_ie, md));
    wait_idle(n);
    check({tag, " R3/R4 duration"}, n, exp_dur(md));
    nvm_read(a, got);
    check({tag, " R3 stored byte"}, got, exp_byte(md, old, d));
    idle(4);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2**AW; i++) mem[i] = 8'($urandom);
    idle(2); por_n = 1; idle(1); rst_n = 1; idle(1);

    // R10 reset state
    rd_reg(0, v); check("R10 addr", v, 0);
    rd_reg(1, v); check("R10 data", v, 0);
    rd_reg(2, v); check("R10 ctrl", v, 0);
    check("R10 stall", stall, 0);
    check("R10 irq", irq, 0);

    // R1 arm window visibility
    wr(2, cw(0, 0, 1, 0, 2'b00));
    rd_reg(2, v); check("R1 arm set", v[2], 1);
    idle(3); rd_reg(2, v); check("R1 arm 4th cycle", v[2], 1);
    idle(1); rd_reg(2, v); check("R1 arm cleared", v[2], 0);

    // R2 no arm, arm+prog together, late start
    mem[8'h10] = 8'h3C;
    wr(0, 8'h10); wr(1, 8'h00);
    wr(2, cw(0, 1, 0, 0, 2'b01));
    rd_reg(2, v); check("R2 unarmed no busy", v[1], 0);
    wr(2, cw(0, 1, 1, 0, 2'b01));
    rd_reg(2, v); check("R2 same-write no busy", v[1], 0);
    idle(5);
    wr(2, cw(0, 0, 1, 0, 2'b01)); idle(4);
    wr(2, cw(0, 1, 0, 0, 2'b01));
    rd_reg(2, v); check("R2 late start ignored", v[1], 0);
    idle(ER + 2);
    check("R2 array untouched", mem[8'h10], 8'h3C);

    // R2/R7/R5 start on last window cycle, stall length
    wr(2, cw(0, 0, 1, 0, 2'b01)); idle(3);
    wr(2, cw(0, 1, 0, 0, 2'b01));
    rd_reg(2, v); check("R2 start in window", v[1], 1);
    check("R7 start stall c1", stall, 1);
    idle(1); check("R7 start stall c2", stall, 1);
    idle(1); check("R7 start stall end", stall, 0);
    wait_idle(n);
    check("R5 prog held then cleared", n, ER - 2);
    check("R3 erase result", mem[8'h10], 8'hFF);

    // R7 read stall and data
    mem[8'h22] = 8'hA5;
    wr(0, 8'h22);
    wr(2, cw(1, 0, 0, 0, 2'b00));
    rd_reg(1, v); check("R7 read data", v, 8'hA5);
    check("R7 read stall c1", stall, 1);
    idle(3); check("R7 read stall c4", stall, 1);
    idle(1); check("R7 read stall end", stall, 0);

    // R8 irq around an operation
    cur_ie = 1;
    wr(2, cw(0, 0, 0, 1, 2'b00));
    check("R8 irq idle", irq, 1);
    mem[8'h30] = 8'hF0;
    wr(0, 8'h30); wr(1, 8'h5A);
    wr(2, cw(0, 0, 1, 1, 2'b10));
    wr(2, cw(0, 1, 0, 1, 2'b10));
    check("R8 irq busy", irq, 0);

    // R6 locks while busy
    wr(0, 8'h31);
    wr(2, cw(1, 0, 0, 1, 2'b01));
    check("R6 ignored read no stall", stall, 0);
    rd_reg(2, v); check("R6 mode locked", v[5:4], 2'b10);
    rd_reg(1, v); check("R6 data unchanged", v, 8'h5A);
    rd_reg(0, v); check("R6 addr locked", v, 8'h30);
    wait_idle(n);
    check("R3 write-only AND", mem[8'h30], 8'h50);
    check("R8 irq back", irq, 1);

    // R4 mode 11
    mem[8'h40] = 8'h77;
    prog_op(2'b11, 8'h40, 8'h00, "mode11");
    check("R4 untouched", mem[8'h40], 8'h77);

    // R9 system reset mid-operation
    mem[8'h50] = 8'h12;
    wr(0, 8'h50);
    wr(2, cw(0, 0, 1, 1, 2'b01));
    wr(2, cw(0, 1, 0, 1, 2'b01));
    idle(3); rst_n = 0; idle(2); rst_n = 1;
    rd_reg(2, v);
    check("R9 busy kept", v[1], 1);
    check("R9 mode kept", v[5:4], 2'b01);
    check("R9 ie cleared", v[3], 0);
    wait_idle(n);
    check("R9 op completed", mem[8'h50], 8'hFF);
    cur_ie = 0;
    wr(2, cw(0, 0, 0, 1, 2'b10)); wr(0, 8'h44);
    rst_n = 0; idle(1); rst_n = 1;
    rd_reg(2, v); check("R9 idle mode cleared", v, 0);
    rd_reg(0, v); check("R9 idle addr cleared", v, 0);
    check("R9 irq low", irq, 0);

    // constrained random program operations
    for (int i = 0; i < 24; i++) begin
      logic [1:0] md;
      md = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
      cur_ie = 1'($urandom);
      prog_op(md, 8'($urandom), 8'($urandom), "rand");
      check("R8 irq idle random", irq, cur_ie);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule